// File: doc/BRIEF.md
# Sequential Signed Multiplier with Booth or Bit-Pair Recoding

This block multiplies two two's-complement operands of `WIDTH` bits and returns the full signed product of `2*WIDTH` bits. It works over several cycles. The multiplier operand is recoded so that each cycle adds one selected multiple of the multiplicand to a running sum. The multiple can be zero, plus or minus the multiplicand, or, in bit-pair mode, plus or minus twice the multiplicand. Before the sum is taken, the multiplicand is sign-extended to the full product width. After each step it is shifted left to the weight of the next group. Negative multipliers need no final sign correction, because the sign bit takes part in the recoding like any other bit.

The parameter `BIT_PAIR` picks the step size:
- With `BIT_PAIR` = 0, the block recodes one bit per cycle (radix-2) and needs `WIDTH` steps.
- With `BIT_PAIR` = 1, the block looks at overlapping bit triples, two bit positions per cycle (radix-4), and needs `(WIDTH+1)/2` steps.

A single-cycle `start` strobe loads both operands while the block is idle. `busy` stays high during the steps. `done` pulses once when the last step finishes, and `product` then holds its value until the next accepted start.

Top module: `booth_mul`

## Requirements
- R1: After reset, `busy`, `done` and `product` are all zero.
- R2: A `start` sampled high while `busy` is low loads the operands, and `busy` is high from the next cycle.
- R3: With `BIT_PAIR`=0, the recoding pair is (current bit, bit below), with an assumed 0 below bit 0. Pair 01 adds +M, pair 10 adds -M, and pairs 00 and 11 add nothing. The final product equals the signed product of the operands.
- R4: With `BIT_PAIR`=1, the triple (bit i+1, bit i, bit i-1) at even i selects the multiple, with an assumed 0 below bit 0:
  - 000 and 111 select 0.
  - 001 and 010 select +M.
  - 011 selects +2M.
  - 100 selects -2M.
  - 101 and 110 select -M.

  The final product equals the signed product of the operands.
- R5: `done` rises exactly `WIDTH` cycles after the accepted start in radix-2 mode, and `(WIDTH+1)/2` cycles after it in bit-pair mode, whatever the operand values.
- R6: `done` is high for exactly one cycle, and it coincides with the first cycle in which `busy` is low again.
- R7: While the block is idle and no start arrives, `product` does not change.
- R8: A `start` sampled while `busy` is high is ignored: the operands it carries do not change the result, and the step count of the running multiply does not change.
- R9: Extreme operands, including the most negative value times itself and alternating bit patterns, give exact signed products without any sign correction step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiply; taken only while idle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | High while steps are in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
The assertions check on every cycle the properties of the handshake:
- an idle start is followed by busy;
- done lasts one cycle and ends a busy period;
- the step counter stays below its limit;
- the product holds while the block is idle.

Only the bench scenarios can show that the recoding is correct. They compare the product for each operand pair, in both modes, with a signed product computed in the bench. They measure the exact latency of each mode. They also show that a start issued mid-run leaves both the result and the latency untouched.

// File: rtl/booth_mul.sv
module booth_mul #(
  parameter int WIDTH    = 8,
  parameter bit BIT_PAIR = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW    = 2 * WIDTH;
  localparam int QW    = WIDTH + 2;
  localparam int SH    = BIT_PAIR ? 2 : 1;
  localparam int STEPS = BIT_PAIR ? (WIDTH + 1) / 2 : WIDTH;
  localparam int CW    = $clog2(STEPS + 1);

  logic [PW-1:0] m_q, acc_q, addend;
  logic [QW-1:0] q_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  assign busy    = busy_q;
  assign done    = done_q;
  assign product = acc_q;

  generate
    if (BIT_PAIR) begin : g_radix4
      always_comb begin
        case (q_q[2:0])
          3'b001, 3'b010: addend = m_q;
          3'b011:         addend = m_q << 1;
          3'b100:         addend = -(m_q << 1);
          3'b101, 3'b110: addend = -m_q;
          default:        addend = '0;
        endcase
      end
    end else begin : g_radix2
      always_comb begin
        case (q_q[1:0])
          2'b01:   addend = m_q;
          2'b10:   addend = -m_q;
          default: addend = '0;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      m_q    <= '0;
      q_q    <= '0;
      acc_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          acc_q  <= '0;
          m_q    <= {{WIDTH{mcand[WIDTH-1]}}, mcand};
          q_q    <= {mplier[WIDTH-1], mplier, 1'b0};
        end
      end else begin
        acc_q <= acc_q + addend;
        m_q   <= m_q << SH;
        q_q   <= {{SH{q_q[QW-1]}}, q_q[QW-1:SH]};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(STEPS - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && $past(busy));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(product));
  p_step_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt_q < CW'(STEPS));
endmodule

// File: tb/booth_mul_tb.sv
module booth_mul_tb;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic st4 = 1'b0, st2 = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic busy4, done4, busy2, done2;
  logic [2*W-1:0] p4, p2;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  booth_mul #(.WIDTH(W), .BIT_PAIR(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(st4), .mcand(a), .mplier(b),
    .busy(busy4), .done(done4), .product(p4));
  booth_mul #(.WIDTH(W), .BIT_PAIR(1'b0)) u_dut_r2 (
    .clk(clk), .rst_n(rst_n), .start(st2), .mcand(a), .mplier(b),
    .busy(busy2), .done(done2), .product(p2));

  localparam logic [15:0] VEC [12] = '{
    16'h0000, 16'h0305, 16'hFD05, 16'h05FD, 16'hFFFF, 16'h8080,
    16'h7F80, 16'h7F7F, 16'h1355, 16'hA955, 16'h3C3C, 16'h81AA};

  function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] x, logic [W-1:0] y);
    longint sx = longint'($signed(x));
    longint sy = longint'($signed(y));
    longint r  = sx * sy;
    return r[2*W-1:0];
  endfunction

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic cur_busy(bit r2);
    return r2 ? busy2 : busy4;
  endfunction
  function automatic logic cur_done(bit r2);
    return r2 ? done2 : done4;
  endfunction
  function automatic logic [2*W-1:0] cur_prod(bit r2);
    return r2 ? p2 : p4;
  endfunction

  // Runs one multiply; optional late start mid-run with other operands.
  task automatic run(bit r2, logic [W-1:0] x, logic [W-1:0] y, bit late,
                     output int cyc, output logic [2*W-1:0] res);
    a = x; b = y;
    if (r2) st2 = 1'b1; else st4 = 1'b1;
    @(negedge clk);
    if (r2) st2 = 1'b0; else st4 = 1'b0;
    chk("R2 busy after start", cur_busy(r2), 1);
    cyc = 0;
    while (!cur_done(r2) && cyc < 100) begin
      if (late && cyc == 1) begin
        a = ~x; b = 8'h6B;
        if (r2) st2 = 1'b1; else st4 = 1'b1;
      end
      @(negedge clk);
      if (r2) st2 = 1'b0; else st4 = 1'b0;
      cyc++;
    end
    if (cyc >= 100) chk("watchdog", 0, 1);
    res = cur_prod(r2);
    chk("R6 busy low with done", cur_busy(r2), 0);
    @(negedge clk);
    chk("R6 done single cycle", cur_done(r2), 0);
  endtask

  initial begin
    int cyc;
    logic [2*W-1:0] res;
    #1;
    chk("R1 reset busy", busy4, 0);
    chk("R1 reset done", done4, 0);
    chk("R1 reset product", p4, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 product after reset release", p2, 0);

    for (int i = 0; i < 12; i++) begin
      run(1'b1, VEC[i][15:8], VEC[i][7:0], 1'b0, cyc, res);
      chk("R3 radix-2 product", res, ref_mul(VEC[i][15:8], VEC[i][7:0]));
      chk("R5 radix-2 latency", cyc, W);
      run(1'b0, VEC[i][15:8], VEC[i][7:0], 1'b0, cyc, res);
      chk("R4 bit-pair product", res, ref_mul(VEC[i][15:8], VEC[i][7:0]));
      chk("R5 bit-pair latency", cyc, W / 2);
    end

    // R9 extremes in both modes
    run(1'b0, 8'h80, 8'h80, 1'b0, cyc, res);
    chk("R9 min*min bit-pair", res, 16'h4000);
    run(1'b1, 8'h55, 8'hAB, 1'b0, cyc, res);
    chk("R9 alternating radix-2", res, ref_mul(8'h55, 8'hAB));

    // R7 product holds while idle
    run(1'b0, 8'hE7, 8'h19, 1'b0, cyc, res);
    a = 8'h11; b = 8'h22;
    repeat (4) @(negedge clk);
    chk("R7 hold bit-pair", p4, ref_mul(8'hE7, 8'h19));
    chk("R7 hold radix-2", p2, ref_mul(8'h55, 8'hAB));

    // R8 start while busy is ignored
    run(1'b1, 8'hC5, 8'h3D, 1'b1, cyc, res);
    chk("R8 radix-2 result", res, ref_mul(8'hC5, 8'h3D));
    chk("R8 radix-2 latency", cyc, W);
    run(1'b0, 8'h9A, 8'hF3, 1'b1, cyc, res);
    chk("R8 bit-pair result", res, ref_mul(8'h9A, 8'hF3));
    chk("R8 bit-pair latency", cyc, W / 2);
    repeat (2) @(negedge clk);
    chk("R8 no restart", busy4, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule